// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Receiver

This block turns a three-wire stereo PCM stream (bit clock, word clock, serial data) into parallel left and right samples in the system clock domain. All three serial lines are resynchronised into the system clock. The bit clock is oversampled, and every rising edge of the bit clock samples one data bit together with the word-clock level.

A 3-bit format code selects one of eight framings: right-justified, left-justified or I2S, at 16, 20 or 24 bits. A polarity bit chooses which word-clock level means the left channel. Right-justified words come from a sliding history register that is copied at each word-clock edge. Left-justified and I2S words are gathered by position, counted from the edge. Each received word is placed at the top of a 24-bit output, with zeros below it. A one-cycle strobe then marks each completed left/right pair.

The format code and the polarity bit are static configuration. They are changed only while the block is held in reset.

Top module: `stereo_serial_rx`

## Requirements
- R1: Data is sampled on rising bit-clock edges and sent MSB first. With format codes 000, 001 and 010, the word is the last 16, 20 or 24 bits received before the word-clock transition that ends the channel slot.
- R2: With format code 011 (24 bits) or 111 (20 bits), the word is the first 24 or 20 bits received from the rising bit-clock edge that first sees the new word-clock level.
- R3: With format codes 100 (16 bits), 110 (20 bits) and 101 (24 bits), the word starts one bit-clock cycle later than the left-justified position.
- R4: With the polarity bit at 0, a high word clock marks the left channel. With the polarity bit at 1, a low word clock marks the left channel.
- R5: The left word of a sample instant precedes its right word. Once the right word is closed by the next word-clock edge, both outputs update in the same cycle and `pair_valid` is high for exactly one cycle. Exactly one strobe is produced per received pair.
- R6: Words of 16 or 20 bits appear in bits 23 down to 8 or 23 down to 4 of the outputs, and the bits below them are zero.
- R7: Serial bits outside the selected word window have no effect on the outputs.
- R8: After reset both outputs are zero and `pair_valid` is low. No strobe is produced for a right word that has no complete left word ahead of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Serial bit clock (asynchronous) |
| lrclk | input | 1 | Word clock, selects the channel |
| sdata | input | 1 | Serial audio data |
| fmt | input | 3 | Framing and width code |
| lr_pol | input | 1 | Word-clock polarity select |
| left_pcm | output | 24 | Left sample, MSB-aligned |
| right_pcm | output | 24 | Right sample, MSB-aligned |
| pair_valid | output | 1 | One-cycle strobe for a new pair |

## Verification
Every combination of the eight format codes and both polarities is driven with 32-bit channel slots. The bits outside the word window are filled with a toggling pattern, so any window placed one bit off, or any leak of filler bits into the word, shows up as a wrong value.

Each configuration carries the following samples:
- an all-ones word, which checks the word length and the zero padding;
- a left word with only its MSB set and a right word with only its LSB set, which checks bit order, alignment and left/right swaps;
- hashed words, which catch bit-level mistakes.

A lead-in right slot and a closing left slot check that a pair strobes only when a whole left word has come before it.

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk,
  input  logic        lrclk,
  input  logic        sdata,
  input  logic [2:0]  fmt,
  input  logic        lr_pol,
  output logic [23:0] left_pcm,
  output logic [23:0] right_pcm,
  output logic        pair_valid
);

  localparam int SW = 24;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] bck_sy, lr_sy, sd_sy;
  logic bck_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bck_sy <= '0;
      lr_sy  <= '0;
      sd_sy  <= '0;
      bck_q  <= 1'b0;
    end else begin
      bck_sy <= {bck_sy[SYNC_STAGES-2:0], bclk};
      lr_sy  <= {lr_sy[SYNC_STAGES-2:0], lrclk};
      sd_sy  <= {sd_sy[SYNC_STAGES-2:0], sdata};
      bck_q  <= bck_sy[TOP];
    end

  wire bit_evt = bck_sy[TOP] & ~bck_q;
  wire lr_in   = lr_sy[TOP];
  wire sd_in   = sd_sy[TOP];

  logic [4:0] wlen;
  logic       rj_mode;
  logic       dly;

  always_comb begin
    rj_mode = 1'b0;
    dly     = 1'b0;
    wlen    = 5'd24;
    case (fmt)
      3'b000: begin rj_mode = 1'b1; wlen = 5'd16; end
      3'b001: begin rj_mode = 1'b1; wlen = 5'd20; end
      3'b010: begin rj_mode = 1'b1; wlen = 5'd24; end
      3'b011: wlen = 5'd24;
      3'b100: begin dly = 1'b1; wlen = 5'd16; end
      3'b101: begin dly = 1'b1; wlen = 5'd24; end
      3'b110: begin dly = 1'b1; wlen = 5'd20; end
      default: wlen = 5'd20;
    endcase
  end

  logic             primed, lr_prev, left_seen;
  logic [SW-1:0]    hist, acc, left_hold;
  logic [CNT_W-1:0] cnt;

  wire lr_edge   = primed & (lr_in != lr_prev);
  wire prev_left = lr_prev ^ lr_pol;

  wire [4:0]    pad       = 5'd24 - wlen;
  wire [SW-1:0] rj_word   = hist << pad;
  wire [SW-1:0] word_done = rj_mode ? rj_word : acc;

  logic [CNT_W-1:0] cnt_eff, pos;
  logic [SW-1:0]    acc_next;

  always_comb begin
    cnt_eff  = lr_edge ? '0 : cnt;
    pos      = cnt_eff - CNT_W'(dly);
    acc_next = lr_edge ? '0 : acc;
    if (cnt_eff >= CNT_W'(dly) && pos < CNT_W'(wlen))
      acc_next[5'd23 - pos[4:0]] = sd_in;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      primed     <= 1'b0;
      lr_prev    <= 1'b0;
      hist       <= '0;
      acc        <= '0;
      cnt        <= '0;
      left_hold  <= '0;
      left_seen  <= 1'b0;
      left_pcm   <= '0;
      right_pcm  <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (bit_evt) begin
        primed  <= 1'b1;
        lr_prev <= lr_in;
        hist    <= {hist[SW-2:0], sd_in};
        acc     <= acc_next;
        if (lr_edge)             cnt <= CNT_W'(1);
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (lr_edge) begin
          if (prev_left) begin
            left_hold <= word_done;
            left_seen <= 1'b1;
          end else if (left_seen) begin
            left_pcm   <= left_hold;
            right_pcm  <= word_done;
            pair_valid <= 1'b1;
            left_seen  <= 1'b0;
          end
        end
      end
    end

  wire [SW-1:0] low_mask = ~({SW{1'b1}} << pad);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  assert_outputs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> ($stable(left_pcm) && $stable(right_pcm)));

  assert_strobe_after_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> $past(bit_evt));

  assert_zero_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (((left_pcm | right_pcm) & low_mask) == '0));

endmodule

// File: tb/stereo_serial_rx_tb_top.sv
module stereo_serial_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BCLK  = 4;
  localparam int SLOT       = 32;
  localparam int NFR        = 4;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [2:0] fmt = 3'd0;
  logic lr_pol = 1'b0;
  logic [23:0] left_pcm, right_pcm;
  logic pair_valid;

  stereo_serial_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .fmt(fmt), .lr_pol(lr_pol), .left_pcm(left_pcm), .right_pcm(right_pcm),
    .pair_valid(pair_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0, got = 0;
  logic [23:0] exp_l [NFR], exp_r [NFR];
  string cur_req = "R1";
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic int wlen_of(input logic [2:0] f);
    case (f)
      3'b000, 3'b100: return 16;
      3'b001, 3'b110, 3'b111: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic int kind_of(input logic [2:0] f);
    if (f <= 3'b010) return 0;
    if (f == 3'b011 || f == 3'b111) return 1;
    return 2;
  endfunction

  function automatic logic [23:0] sample_of(input int cfg, input int fr, input int ch, input int w);
    logic [31:0] h;
    logic [23:0] m;
    m = 24'hFFFFFF >> (24 - w);
    if (fr == 0) return m;
    if (fr == 1) return (ch == 0) ? (24'd1 << (w - 1)) : 24'd1;
    h = (32'(cfg) * 32'd40503 + 32'(fr) * 32'd9973 + 32'(ch) * 32'd7 + 32'd1) * 32'd2654435761;
    return h[31:8] & m;
  endfunction

  function automatic logic slot_bit(input int kind, input int w, input logic [23:0] s, input int b, input int ch);
    logic junk;
    junk = b[0] ^ ch[0] ^ 1'b1;
    case (kind)
      0: if (b >= SLOT - w) return s[w - 1 - (b - (SLOT - w))];
      1: if (b < w) return s[w - 1 - b];
      default: if (b >= 1 && b <= w) return s[w - b];
    endcase
    return junk;
  endfunction

  task automatic send_bit(input logic lr, input logic d);
    @(negedge clk);
    bclk = 1'b0; lrclk = lr; sdata = d;
    repeat (HALF_BCLK) @(negedge clk);
    bclk = 1'b1;
    repeat (HALF_BCLK - 1) @(negedge clk);
  endtask

  task automatic send_slot(input logic lr, input int kind, input int w, input logic [23:0] s, input int ch);
    for (int b = 0; b < SLOT; b++) send_bit(lr, slot_bit(kind, w, s, b, ch));
  endtask

  always @(negedge clk)
    if (rst_n && pair_valid && !done) begin
      if (got < NFR) begin
        check({left_pcm, right_pcm} == {exp_l[got], exp_r[got]}, cur_req,
              {left_pcm, right_pcm}, {exp_l[got], exp_r[got]});
        check(((left_pcm | right_pcm) & ~(24'hFFFFFF << (24 - wlen_of(fmt)))) == 24'd0,
              "R6", 48'(left_pcm | right_pcm), 48'd0);
      end
      got++;
    end

  task automatic finish_run;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog R5 actual=hung expected=complete");
    finish_run();
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      for (int f = 0; f < 8; f++) begin
        int cfg, w, kind;
        cfg = p * 8 + f;
        rst_n = 1'b0; bclk = 1'b0; lrclk = 1'b0; sdata = 1'b0;
        fmt = 3'(f); lr_pol = p[0];
        w = wlen_of(fmt); kind = kind_of(fmt);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R8: reset state
        check(pair_valid == 1'b0 && left_pcm == 24'd0 && right_pcm == 24'd0, "R8",
              {left_pcm, right_pcm}, 48'd0);
        cur_req = (kind == 0) ? "R1 R7" : (kind == 1) ? "R2 R7" : "R3 R7";
        if (p == 1) cur_req = {cur_req, " R4"};
        got = 0;
        for (int fr = 0; fr < NFR; fr++) begin
          exp_l[fr] = sample_of(cfg, fr, 0, w) << (24 - w);
          exp_r[fr] = sample_of(cfg, fr, 1, w) << (24 - w);
        end
        // lead-in right slot must not strobe (R8)
        send_slot(p[0], kind, w, 24'h5A5A5A & (24'hFFFFFF >> (24 - w)), 1);
        for (int fr = 0; fr < NFR; fr++) begin
          send_slot(~p[0], kind, w, sample_of(cfg, fr, 0, w), 0);
          if (fr == 0) check(got == 0, "R8", 48'(got), 48'd0);
          send_slot(p[0], kind, w, sample_of(cfg, fr, 1, w), 1);
        end
        send_slot(~p[0], kind, w, 24'd0, 0);
        repeat (10) @(negedge clk);
        // R5: one strobe per pair
        check(got == NFR, "R5", 48'(got), 48'(NFR));
      end
    end
    finish_run();
  end
endmodule